// File: doc/BRIEF.md
# Frame-Counted SPI Transfer Sequencer

This block is the transfer engine that sits between the word FIFOs and the bit shifter of an SPI master. A control word sets the enable, the chip-select persistence bit and a frame count. From it the sequencer runs a burst. For each frame it takes one word from the transmit FIFO, passes it to the shifter with a start pulse, and waits for the shifter's done pulse. It then hands the received word to the receive FIFO and counts the frame against the programmed burst length. It drives a single active-low chip select. When a burst ends, it raises the transmit-done and receive-ready indications. The counter then reloads by itself, so the next burst can begin without any software action.

The control word and a six-bit frame-size field are held here. The frame size is only stored and presented to the shifter side. The FIFOs and the serial shifter are outside the block. The FIFOs connect through an empty flag plus pop or push strobes. The shifter connects through a one-cycle start and done handshake. Writing a control word with its top bit set returns the whole sequencer to its power-up state.

Top module: `spi_frame_seq`

## Requirements
- R1: After reset, `ctrl_q` reads 0x80000102, `frame_size` reads 4, `cs_n` is high, both status flags are 0, both raw event flags are 0, and the remaining frame count is 1.
- R2: A control write stores `ctrl_wdata` in `ctrl_q`, and loads the remaining frame count from bits [23:8] of the written word.
- R3: A frame begins only when all of these hold: control bit 0 (enable) is set, `tx_empty` is low, and the remaining count is non-zero. A frame begins with a one-cycle `tx_pop`. In the next cycle `sh_start` pulses, with the popped word on `sh_txd`.
- R4: `cs_n` is low from the cycle after the pop until the shifter reports done. Only one frame is in flight at a time. In the cycle of `sh_done`, `rx_push` pulses with `sh_rxd` on `rx_data`, so every word sent produces exactly one received word, in order.
- R5: While control bit 26 (persistence) is clear, `cs_n` returns high after every frame. It stays high for at least one clock before the next frame pulls it low.
- R6: While control bit 26 is set, `cs_n` stays low between the frames of a burst. It is released only when the burst ends.
- R7: When the last frame of a burst completes, `cs_n` goes high and the remaining count reloads from control bits [23:8]. `sts_txdone`, `sts_rxrdy`, `raw_txdone` and `raw_rxrdy` are all set.
- R8: The start of each frame clears `sts_txdone` and `sts_rxrdy`. The raw flags are cleared only by `raw_clr`: bit 0 clears `raw_txdone` and bit 1 clears `raw_rxrdy`.
- R9: A control write with bit 31 set restores every register and flag to its R1 value, whatever the rest of the written word holds.
- R10: A frame-size write of a value above 32 is ignored. Any frame-size write while control bit 0 is set is also ignored. `frame_size` never exceeds 32.
- R11: If the programmed frame count is 0, no frame starts, even with enable set and data waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 32 | Control word write data |
| fsz_wr | input | 1 | Frame-size write strobe |
| fsz_wdata | input | 6 | Frame-size write data |
| raw_clr | input | 2 | Raw event clear, bit 0 done, bit 1 ready |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | DW | Transmit FIFO head word |
| tx_pop | output | 1 | Transmit FIFO pop strobe |
| sh_start | output | 1 | Shifter start pulse |
| sh_txd | output | DW | Word handed to the shifter |
| sh_done | input | 1 | Shifter done pulse |
| sh_rxd | input | DW | Word received by the shifter |
| rx_push | output | 1 | Receive FIFO push strobe |
| rx_data | output | DW | Word pushed to the receive FIFO |
| cs_n | output | 1 | Active-low chip select |
| sts_txdone | output | 1 | Status: burst transmit done |
| sts_rxrdy | output | 1 | Status: burst receive ready |
| raw_txdone | output | 1 | Raw event: burst transmit done |
| raw_rxrdy | output | 1 | Raw event: burst receive ready |
| ctrl_q | output | 32 | Stored control word |
| frame_size | output | 6 | Stored frame size |

## Verification
The bench counts chip-select edges over whole bursts. A design that ignored persistence would show one release per frame where only one per burst belongs. A design that never let the select return high between frames would show too few falling edges. It sends words while enable is off and while the frame count is zero, then checks that no start appears. A guard that leaked would produce extra shifter starts and scoreboard mismatches. It runs two bursts back to back with no new control write, so a counter that failed to reload would stall the second burst. It also checks that the status flags drop at the first frame while the raw flags do not. It rejects oversize and locked frame-size writes, and it applies a soft reset partway through a burst. Stale control bits, a held select or sticky flags would then show at the ports.

// File: rtl/spi_seq_pkg.sv
// Shared constants and types for the frame-counted SPI sequencer.
// Assumes a 32-bit control word whose field positions are fixed.
package spi_seq_pkg;
    localparam int          CTRL_W      = 32;
    localparam logic [31:0] CTRL_RST    = 32'h8000_0102;
    localparam int          EN_BIT      = 0;
    localparam int          PERSIST_BIT = 26;
    localparam int          SRST_BIT    = 31;
    localparam int          CNT_LSB     = 8;
    localparam int          CNT_MSB     = 23;
    localparam int          CNT_W       = CNT_MSB - CNT_LSB + 1;
    localparam int          FSZ_W       = 6;
    localparam logic [5:0]  FSZ_RST     = 6'd4;
    localparam logic [5:0]  FSZ_MAX     = 6'd32;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_BUSY   = 2'd2
    } seq_state_t;
endpackage

// File: rtl/spi_seq_regs.sv
// Holds the control word and the frame size.
// Assumes writes arrive as single-cycle strobes. A control write with
// the soft-reset bit set restores the defaults and wins over every other write.
module spi_seq_regs
    import spi_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              fsz_wr,
    input  logic [FSZ_W-1:0]  fsz_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [FSZ_W-1:0]  frame_size,
    output logic              soft_rst
);
    logic fsz_ok;

    // Detect a control write that requests a full reset.
    assign soft_rst = ctrl_wr && ctrl_wdata[SRST_BIT];
    // A size write counts only when unlocked and in range.
    assign fsz_ok   = fsz_wr && !ctrl_q[EN_BIT] && (fsz_wdata <= FSZ_MAX);

    // Register update with the reset sources taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            ctrl_q     <= CTRL_RST;
            frame_size <= FSZ_RST;
        end else begin
            if (ctrl_wr) ctrl_q     <= ctrl_wdata;
            if (fsz_ok)  frame_size <= fsz_wdata;
        end
    end

    AST_FSZ_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_size <= FSZ_MAX); // R10
    AST_FSZ_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (fsz_wr && ctrl_q[EN_BIT] && !ctrl_wr) |=> $stable(frame_size)); // R10
endmodule

// File: rtl/spi_seq_count.sv
// Remaining-frame counter for one burst.
// Assumes a load never coincides with a wanted decrement; the load wins.
// A decrement from one reloads the programmed length.
module spi_seq_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    input  logic [CW-1:0] reload_val,
    output logic          nonzero,
    output logic          last
);
    logic [CW-1:0] remaining;

    assign nonzero = (remaining != '0);
    assign last    = (remaining == CW'(1));

    // Count down per frame and reload at the end of a burst.
    always_ff @(posedge clk) begin
        if (!rst_n)     remaining <= CW'(1);
        else if (load)  remaining <= load_val;
        else if (dec)   remaining <= last ? reload_val : remaining - CW'(1);
    end

    AST_COUNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (remaining == $past(load_val))); // R2
    AST_COUNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && last && !load) |=> (remaining == $past(reload_val))); // R7
endmodule

// File: rtl/spi_seq_engine.sv
// Frame state machine: pops a word, starts the shifter, waits for done,
// pushes the reply, and drives the chip select and burst flags.
// Assumes sh_done pulses for one cycle, only after sh_start.
module spi_seq_engine
    import spi_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          en,
    input  logic          persist,
    input  logic          cnt_nz,
    input  logic          cnt_last,
    input  logic [1:0]    raw_clr,
    input  logic          tx_empty,
    input  logic [DW-1:0] tx_data,
    output logic          tx_pop,
    output logic          sh_start,
    output logic [DW-1:0] sh_txd,
    input  logic          sh_done,
    input  logic [DW-1:0] sh_rxd,
    output logic          rx_push,
    output logic [DW-1:0] rx_data,
    output logic          cnt_dec,
    output logic          cs_n,
    output logic          sts_txdone,
    output logic          sts_rxrdy,
    output logic          raw_txdone,
    output logic          raw_rxrdy
);
    seq_state_t    state;
    logic [DW-1:0] txd_q;
    logic          go;
    logic          finish;

    // Decide when a frame may begin and when a frame or burst ends.
    assign go       = (state == ST_IDLE) && en && !tx_empty && cnt_nz && !abort;
    assign tx_pop   = go;
    assign sh_start = (state == ST_LAUNCH) && !abort;
    assign sh_txd   = txd_q;
    assign rx_push  = (state == ST_BUSY) && sh_done && !abort;
    assign rx_data  = sh_rxd;
    assign cnt_dec  = rx_push;
    assign finish   = rx_push && cnt_last;

    // Step through pop, launch and wait-for-done.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) state <= ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:   if (go) state <= ST_LAUNCH;
                ST_LAUNCH: state <= ST_BUSY;
                ST_BUSY:   if (sh_done) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Capture the popped word for the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n)  txd_q <= '0;
        else if (go) txd_q <= tx_data;
    end

    // Pull select low per frame and release it per frame or per burst.
    always_ff @(posedge clk) begin
        if (!rst_n || abort)                     cs_n <= 1'b1;
        else if (go)                             cs_n <= 1'b0;
        else if (rx_push && (!persist || cnt_last)) cs_n <= 1'b1;
    end

    // Status flags: cleared at frame start, set at burst end.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            sts_txdone <= 1'b0;
            sts_rxrdy  <= 1'b0;
        end else if (go) begin
            sts_txdone <= 1'b0;
            sts_rxrdy  <= 1'b0;
        end else if (finish) begin
            sts_txdone <= 1'b1;
            sts_rxrdy  <= 1'b1;
        end
    end

    // Raw events: set at burst end, cleared only by request.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            raw_txdone <= 1'b0;
            raw_rxrdy  <= 1'b0;
        end else begin
            if (finish)          raw_txdone <= 1'b1;
            else if (raw_clr[0]) raw_txdone <= 1'b0;
            if (finish)          raw_rxrdy  <= 1'b1;
            else if (raw_clr[1]) raw_rxrdy  <= 1'b0;
        end
    end

    AST_POP_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> (en && !tx_empty && cnt_nz)); // R3
    AST_NO_COUNT_ZERO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_nz |-> !tx_pop); // R11
    AST_START_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n)
        sh_start |-> !cs_n); // R4
    AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !tx_pop); // R4
    AST_CS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && !persist) |=> cs_n); // R5
    AST_BURST_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (finish && !abort) |=> (sts_txdone && sts_rxrdy && raw_txdone && raw_rxrdy && cs_n)); // R7
endmodule

// File: rtl/spi_frame_seq.sv
// Top of the frame-counted SPI sequencer: control registers, the frame
// counter and the frame engine. Assumes the FIFOs and the bit shifter
// are outside and follow the strobe and handshake described on the ports.
module spi_frame_seq
    import spi_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              fsz_wr,
    input  logic [FSZ_W-1:0]  fsz_wdata,
    input  logic [1:0]        raw_clr,
    input  logic              tx_empty,
    input  logic [DW-1:0]     tx_data,
    output logic              tx_pop,
    output logic              sh_start,
    output logic [DW-1:0]     sh_txd,
    input  logic              sh_done,
    input  logic [DW-1:0]     sh_rxd,
    output logic              rx_push,
    output logic [DW-1:0]     rx_data,
    output logic              cs_n,
    output logic              sts_txdone,
    output logic              sts_rxrdy,
    output logic              raw_txdone,
    output logic              raw_rxrdy,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [FSZ_W-1:0]  frame_size
);
    logic             soft_rst;
    logic             cnt_nz;
    logic             cnt_last;
    logic             cnt_dec;
    logic [CNT_W-1:0] cnt_load_val;

    // Soft reset loads a count of one; a normal write loads its field.
    assign cnt_load_val = soft_rst ? CNT_W'(1) : ctrl_wdata[CNT_MSB:CNT_LSB];

    spi_seq_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .fsz_wr     (fsz_wr),
        .fsz_wdata  (fsz_wdata),
        .ctrl_q     (ctrl_q),
        .frame_size (frame_size),
        .soft_rst   (soft_rst)
    );

    spi_seq_count #(.CW(CNT_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ctrl_wr),
        .load_val   (cnt_load_val),
        .dec        (cnt_dec),
        .reload_val (ctrl_q[CNT_MSB:CNT_LSB]),
        .nonzero    (cnt_nz),
        .last       (cnt_last)
    );

    spi_seq_engine #(.DW(DW)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (soft_rst),
        .en         (ctrl_q[EN_BIT]),
        .persist    (ctrl_q[PERSIST_BIT]),
        .cnt_nz     (cnt_nz),
        .cnt_last   (cnt_last),
        .raw_clr    (raw_clr),
        .tx_empty   (tx_empty),
        .tx_data    (tx_data),
        .tx_pop     (tx_pop),
        .sh_start   (sh_start),
        .sh_txd     (sh_txd),
        .sh_done    (sh_done),
        .sh_rxd     (sh_rxd),
        .rx_push    (rx_push),
        .rx_data    (rx_data),
        .cnt_dec    (cnt_dec),
        .cs_n       (cs_n),
        .sts_txdone (sts_txdone),
        .sts_rxrdy  (sts_rxrdy),
        .raw_txdone (raw_txdone),
        .raw_rxrdy  (raw_rxrdy)
    );

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctrl_q == CTRL_RST && frame_size == FSZ_RST && cs_n)); // R9
endmodule

// File: tb/spi_frame_seq_tb_top.sv
// Scoreboard bench: the driver queues the expected shifter and receive
// words, and a monitor compares them as the sequencer produces them.
module spi_frame_seq_tb_top;
    localparam int DW = 32;
    localparam logic [31:0] RX_XOR = 32'hA5A5_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr = 1'b0;
    logic [31:0]   ctrl_wdata = '0;
    logic          fsz_wr = 1'b0;
    logic [5:0]    fsz_wdata = '0;
    logic [1:0]    raw_clr = '0;
    logic          tx_empty;
    logic [DW-1:0] tx_data;
    logic          tx_pop, sh_start, rx_push, cs_n;
    logic [DW-1:0] sh_txd, rx_data;
    logic          sh_done = 1'b0;
    logic [DW-1:0] sh_rxd = '0;
    logic          sts_txdone, sts_rxrdy, raw_txdone, raw_rxrdy;
    logic [31:0]   ctrl_q;
    logic [5:0]    frame_size;

    int vectors = 0;
    int miscompares = 0;
    int starts = 0;
    int rises = 0;
    int falls = 0;
    logic prev_cs = 1'b1;
    logic finished = 1'b0;

    logic [DW-1:0] exp_tx[$];
    logic [DW-1:0] exp_rx[$];

    logic [DW-1:0] tmem [0:15];
    int wp = 0;
    int rp = 0;
    logic [DW-1:0] sh_cap = '0;
    logic [2:0]    sh_cnt = '0;

    always #10 clk = ~clk;

    spi_frame_seq #(.DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .fsz_wr(fsz_wr), .fsz_wdata(fsz_wdata), .raw_clr(raw_clr),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .sh_start(sh_start), .sh_txd(sh_txd), .sh_done(sh_done), .sh_rxd(sh_rxd),
        .rx_push(rx_push), .rx_data(rx_data), .cs_n(cs_n),
        .sts_txdone(sts_txdone), .sts_rxrdy(sts_rxrdy),
        .raw_txdone(raw_txdone), .raw_rxrdy(raw_rxrdy),
        .ctrl_q(ctrl_q), .frame_size(frame_size)
    );

    // Transmit FIFO model.
    assign tx_empty = (wp == rp);
    assign tx_data  = tmem[rp % 16];
    always @(posedge clk) if (tx_pop) rp <= rp + 1;

    // Shifter model: done pulse three cycles after start.
    always @(posedge clk) begin
        sh_done <= 1'b0;
        if (sh_start) begin
            sh_cnt <= 3'd3;
            sh_cap <= sh_txd;
        end else if (sh_cnt != 0) begin
            sh_cnt <= sh_cnt - 3'd1;
            if (sh_cnt == 3'd1) begin
                sh_done <= 1'b1;
                sh_rxd  <= sh_cap ^ RX_XOR;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Monitor: scoreboard compare and select edge counting.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sh_start) begin
                starts++;
                check("R4 select low at start", {31'd0, cs_n}, 32'd0);
                if (exp_tx.size() == 0) check("R3 unexpected start", 32'd1, 32'd0);
                else check("R3 shifter word", sh_txd, exp_tx.pop_front());
            end
            if (rx_push) begin
                if (exp_rx.size() == 0) check("R4 unexpected push", 32'd1, 32'd0);
                else check("R4 received word", rx_data, exp_rx.pop_front());
            end
            if (prev_cs && !cs_n) falls++;
            if (!prev_cs && cs_n) rises++;
            prev_cs = cs_n;
        end
    end

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic wr_fsz(input logic [5:0] v);
        @(negedge clk); fsz_wr = 1'b1; fsz_wdata = v;
        @(negedge clk); fsz_wr = 1'b0;
    endtask

    task automatic send(input logic [DW-1:0] w);
        @(negedge clk);
        tmem[wp % 16] = w;
        exp_tx.push_back(w);
        exp_rx.push_back(w ^ RX_XOR);
        wp = wp + 1;
    endtask

    task automatic wait_idle();
        while (!tx_empty) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    task automatic zero_counts();
        starts = 0; rises = 0; falls = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            vectors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 ctrl", ctrl_q, 32'h8000_0102);
        check("R1 frame size", {26'd0, frame_size}, 32'd4);
        check("R1 select", {31'd0, cs_n}, 32'd1);
        check("R1 flags", {28'd0, sts_txdone, sts_rxrdy, raw_txdone, raw_rxrdy}, 32'd0);

        // R10 frame-size writes
        wr_fsz(6'd20); check("R10 size accepted", {26'd0, frame_size}, 32'd20);
        wr_fsz(6'd40); check("R10 oversize ignored", {26'd0, frame_size}, 32'd20);
        wr_fsz(6'd32); check("R10 max accepted", {26'd0, frame_size}, 32'd32);
        wr_fsz(6'd63); check("R10 oversize ignored", {26'd0, frame_size}, 32'd32);

        // R2, R5, R7: burst of 3, select pulses per frame
        wr_ctrl(32'h0000_0301);
        check("R2 ctrl stored", ctrl_q, 32'h0000_0301);
        wr_fsz(6'd8); check("R10 locked while enabled", {26'd0, frame_size}, 32'd32);
        zero_counts();
        send(32'h1111_0001); send(32'h2222_0002); send(32'h3333_0003);
        wait_idle();
        check("R3 starts", starts, 32'd3);
        check("R5 select releases", rises, 32'd3);
        check("R5 select assertions", falls, 32'd3);
        check("R7 flags set", {28'd0, sts_txdone, sts_rxrdy, raw_txdone, raw_rxrdy}, 32'hF);
        check("R7 select idle", {31'd0, cs_n}, 32'd1);

        // R8 raw clear leaves status
        @(negedge clk); raw_clr = 2'b11;
        @(negedge clk); raw_clr = 2'b00;
        check("R8 raw cleared, status held", {28'd0, sts_txdone, sts_rxrdy, raw_txdone, raw_rxrdy}, 32'hC);

        // R6 persistent select over a burst of 2
        wr_ctrl(32'h0400_0201);
        zero_counts();
        send(32'h4444_0004);
        wait_idle();
        check("R8 status cleared at frame start", {28'd0, sts_txdone, sts_rxrdy, raw_txdone, raw_rxrdy}, 32'h0);
        check("R6 select held mid-burst", {31'd0, cs_n}, 32'd0);
        send(32'h5555_0005);
        wait_idle();
        check("R6 one release per burst", rises, 32'd1);
        check("R6 one assertion per burst", falls, 32'd1);
        check("R7 flags at burst end", {28'd0, sts_txdone, sts_rxrdy, raw_txdone, raw_rxrdy}, 32'hF);

        // R7 reload: a second burst of 2 with no control write
        zero_counts();
        send(32'h6666_0006);
        wait_idle();
        check("R7 reloaded count runs", starts, 32'd1);
        check("R7 mid-burst status low", {31'd0, sts_txdone}, 32'd0);
        send(32'h7777_0007);
        wait_idle();
        check("R7 second burst done", {30'd0, sts_txdone, cs_n}, 32'd3);

        // R3 enable off blocks frames
        wr_ctrl(32'h0000_0300);
        zero_counts();
        send(32'h8888_0008);
        repeat (20) @(negedge clk);
        check("R3 no start while disabled", starts, 32'd0);
        check("R3 word left in FIFO", {31'd0, tx_empty}, 32'd0);
        wr_ctrl(32'h0000_0301);
        wait_idle();
        check("R3 start once enabled", starts, 32'd1);

        // R11 zero frame count blocks frames
        wr_ctrl(32'h0000_0001);
        zero_counts();
        send(32'h9999_0009);
        repeat (20) @(negedge clk);
        check("R11 no start at count zero", starts, 32'd0);
        wr_ctrl(32'h0000_0101);
        wait_idle();
        check("R11 start after count set", starts, 32'd1);
        check("R7 single-frame burst flags", {31'd0, sts_txdone}, 32'd1);

        // R9 soft reset mid-burst
        wr_ctrl(32'h0400_0501);
        send(32'hAAAA_000A);
        wait_idle();
        check("R6 select held before soft reset", {31'd0, cs_n}, 32'd0);
        wr_ctrl(32'h8000_0000);
        check("R9 ctrl restored", ctrl_q, 32'h8000_0102);
        check("R9 frame size restored", {26'd0, frame_size}, 32'd4);
        check("R9 select released", {31'd0, cs_n}, 32'd1);
        check("R9 flags cleared", {28'd0, sts_txdone, sts_rxrdy, raw_txdone, raw_rxrdy}, 32'h0);

        // R4 scoreboard drained
        check("R4 pending shifter words", exp_tx.size(), 32'd0);
        check("R4 pending received words", exp_rx.size(), 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule